// File: doc/BRIEF.md
# Prescaled Partitioned Binary Up-Counter

This block is a long synchronous binary up-counter whose clock period does not grow with its width. The count is cut into sub-blocks. The least significant block is a single bit, and each block above it is wider than the ones below. A higher block advances only in the cycle in which every bit below it is one. That condition recurs at a fixed low rate, so the wide upper blocks change rarely and have many cycles in which to settle.

Each block above the lowest keeps a small twisted-ring (Johnson) counter. That ring follows the value of the bits beneath the block and flags their all-ones phase. The flag comes from a two-input decode of ring flops, never from a wide AND over the lower bits. The block widths come from a top-down split. The top block takes the total width minus ceil(log2) of that width, and the remaining low part is split again in the same way. Low parts of three bits or fewer split off a single bit.

A user drives the count enable and reads the full binary value on every cycle. A terminal-count pulse marks the last state before the count wraps.

Top module: `psc_counter`

## Requirements
- R1: A synchronous active-high reset clears the whole count to zero; in the first cycle after reset the count reads zero.
- R2: In every cycle with the count enable high, the count at the next clock edge equals the present count plus one, modulo 2^WIDTH.
- R3: While the count enable is low, the count is held unchanged at the next clock edge.
- R4: An enabled step from the all-ones value gives zero.
- R5: The terminal-count output is high exactly in a cycle where the count enable is high and every count bit is one; it is low in every other cycle.
- R6: Carries into every block take effect in the same step that clears the bits below, so the count stays plain binary across all block boundaries. In a 12-bit instance the blocks are 8, 2, 1 and 1 bits from the top, so steps that land on multiples of 16 enter the top block.
- R7: The partition rule gives top-to-bottom block widths of 58, 3, 2, 1 for 64 bits and 121, 4, 2, 1 for 128 bits. These widths are exposed by the package function that reports the width of block k, with k counted from the least significant block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; high advances the count by one |
| count_o | output | WIDTH | Present binary count value |
| tc_o | output | 1 | Terminal count: enable high while the count is all ones |

## Verification
Each block has a ring flag that must stay in step with the bits below it. If a ring falls out of step, the block above it advances at the wrong value of the low bits. That error shows at the count output at the first clock edge where the low part crosses its all-ones point, which is at most 2^(bits below) enabled cycles away. A wrong top-block "full" flag shows as a missing or spurious terminal-count pulse in the all-ones cycle. The bench therefore compares every cycle's count and terminal count against a plain integer model. It runs through complete wraps, so every boundary and every ring phase is reached.

// File: rtl/psc_pkg.sv
package psc_pkg;

    // Width of the low part that remains after splitting off the top block.
    function automatic int split_low(input int r);
        if (r >= 4) return $clog2(r);
        return 1;
    endfunction

    // Remaining low width after j top-down splits.
    function automatic int rem_at(input int n, input int j);
        int r;
        r = n;
        for (int i = 0; i < 32; i++) begin
            if (i < j && r > 1) r = split_low(r);
        end
        return r;
    endfunction

    // Number of blocks for an n-bit counter.
    function automatic int num_blocks(input int n);
        int r;
        int c;
        r = n;
        c = 1;
        for (int i = 0; i < 32; i++) begin
            if (r > 1) begin
                r = split_low(r);
                c++;
            end
        end
        return c;
    endfunction

    // Bit offset of block k, counted from the least significant block.
    function automatic int blk_lsb(input int n, input int k);
        if (k == 0) return 0;
        return rem_at(n, num_blocks(n) - k);
    endfunction

    // Width of block k, counted from the least significant block.
    function automatic int blk_width(input int n, input int k);
        return rem_at(n, num_blocks(n) - 1 - k) - blk_lsb(n, k);
    endfunction

    // Per-block control bundle.
    typedef struct packed {
        logic low_done;  // every bit below this block is one
        logic adv;       // block advances at this edge
        logic full;      // block value is all ones
    } blk_ctl_t;

endpackage

// File: rtl/psc_twist_ring.sv
// Twisted-ring tracker of the bits below a block: STATES phases with STATES/2 flops.
module psc_twist_ring #(
    parameter int STATES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic last
);
    localparam int M = (STATES < 2) ? 1 : STATES / 2;

    logic [M-1:0] st;

    generate
        if (M == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)      st <= '0;
                else if (adv) st <= ~st;
            end
            assign last = st[0];
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)      st <= '0;
                else if (adv) st <= {~st[0], st[M-1:1]};
            end
            // final phase is 0..01
            assign last = st[0] & ~st[1];
        end
    endgenerate

endmodule

// File: rtl/psc_block.sv
// One counter sub-block with its own incrementer and a registered all-ones flag.
module psc_block #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] val,
    output logic         full
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] NEAR = ALL1 - W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            val  <= '0;
            full <= 1'b0;
        end else if (adv) begin
            val  <= val + W'(1);
            full <= (val == NEAR);
        end
    end

endmodule

// File: rtl/psc_counter.sv
module psc_counter #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [WIDTH-1:0] count_o,
    output logic             tc_o
);
    import psc_pkg::*;

    localparam int NB = num_blocks(WIDTH);

    blk_ctl_t ctl [NB];

    generate
        for (genvar k = 0; k < NB; k++) begin : g_blk
            localparam int LSB = blk_lsb(WIDTH, k);
            localparam int BW  = blk_width(WIDTH, k);

            if (k == 0) begin : g_base
                assign ctl[k].low_done = 1'b1;
            end else begin : g_ring
                psc_twist_ring #(.STATES(2 ** LSB)) u_ring (
                    .clk  (clk),
                    .rst  (rst),
                    .adv  (cnt_en),
                    .last (ctl[k].low_done)
                );
            end

            assign ctl[k].adv = cnt_en & ctl[k].low_done;

            psc_block #(.W(BW)) u_blk (
                .clk  (clk),
                .rst  (rst),
                .adv  (ctl[k].adv),
                .val  (count_o[LSB +: BW]),
                .full (ctl[k].full)
            );
        end
    endgenerate

    assign tc_o = cnt_en & ctl[NB-1].low_done & ctl[NB-1].full;

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [WIDTH-1:0] count_o,
    input logic             tc_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (count_o == '0)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst) cnt_en |=> (count_o == $past(count_o) + WIDTH'(1))); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(count_o)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) (cnt_en && (&count_o)) |=> (count_o == '0)); // R4
    AST_TC_EXACT: assert property (@(posedge clk) disable iff (rst) tc_o == (cnt_en && (&count_o))); // R5
endmodule

bind psc_counter psc_checker #(.WIDTH(WIDTH)) u_psc_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .count_o (count_o),
    .tc_o    (tc_o)
);

// File: tb/test_psc_counter.sv
module test_psc_counter;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam logic [CW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnt_en = 1'b0;
    logic [CW-1:0] count_o;
    logic          tc_o;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [CW-1:0] cnt;
        logic          tc;
        string         tag;
    } item_t;

    item_t exp_q [$];

    logic [CW-1:0] model = '0;
    logic          prev_en = 1'b0;
    logic          after_rst = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    psc_counter #(.WIDTH(CW)) i_psc_counter (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .count_o (count_o),
        .tc_o    (tc_o)
    );

    // Driver: applies one cycle of enable and records the expected outputs.
    task automatic step(input logic e);
        item_t it;
        @(negedge clk);
        cnt_en = e;
        it.cnt = model;
        it.tc  = e && (model == ONES);
        if (after_rst)              it.tag = "R1";
        else if (!prev_en)          it.tag = "R3";
        else if (model == '0)       it.tag = "R4";
        else if (model[3:0] == 4'h0) it.tag = "R6";
        else                        it.tag = "R2";
        exp_q.push_back(it);
        after_rst = 1'b0;
        prev_en = e;
        if (e) model = model + CW'(1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cnt_en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cnt_en = 1'b0;
        model = '0;
        after_rst = 1'b1;
    endtask

    task automatic check_int(input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s partition: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor: compares outputs after each driven cycle.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                total++;
                if (count_o !== it.cnt) begin
                    bad++;
                    $display("FAIL %s count: got %0h expected %0h", it.tag, count_o, it.cnt);
                end
                total++;
                if (tc_o !== it.tc) begin
                    bad++;
                    $display("FAIL R5 tc at count %0h: got %0b expected %0b", it.cnt, tc_o, it.tc);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        // R7: partition rule at 64 and 128 bits
        check_int("R7 w64 top", psc_pkg::blk_width(64, 3), 58);
        check_int("R7 w64 b2", psc_pkg::blk_width(64, 2), 3);
        check_int("R7 w64 b1", psc_pkg::blk_width(64, 1), 2);
        check_int("R7 w64 b0", psc_pkg::blk_width(64, 0), 1);
        check_int("R7 w128 top", psc_pkg::blk_width(128, 3), 121);
        check_int("R7 w128 b2", psc_pkg::blk_width(128, 2), 4);
        check_int("R7 w128 b1", psc_pkg::blk_width(128, 1), 2);
        check_int("R7 w128 b0", psc_pkg::blk_width(128, 0), 1);

        // R1: power-up reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cnt_en = 1'b0;

        // R2/R6: steady counting across the low block boundaries
        for (int i = 0; i < 40; i++) step(1'b1);
        // R3: alternating enable
        for (int i = 0; i < 40; i++) step(i[0]);
        // R3: long hold at a value whose low bits are all ones
        while (model[3:0] != 4'hF) step(1'b1);
        for (int i = 0; i < 6; i++) step(1'b0);
        step(1'b1);
        // R4/R5: full run through the wrap
        for (int i = 0; i < 4200; i++) step(1'b1);
        // irregular enable pattern through a further wrap
        lf = 16'hACE1;
        for (int i = 0; i < 7000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[3]);
        end
        // R1: reset in the middle of a run
        do_reset();
        for (int i = 0; i < 20; i++) step(1'b1);
        // R4/R5: hold at all ones, then wrap
        while (model != ONES) step(1'b1);
        step(1'b0);
        step(1'b0);
        step(1'b1);
        step(1'b1);

        @(negedge clk);
        #3;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule